// File: doc/BRIEF.md
# Private Interrupt Pending Tracker

This block keeps the pending state of a bank of private interrupt lines. Each line is first brought into the clock domain by a synchroniser, and the synchronised level is recorded every cycle. A per-line mode bit says whether the line is edge-triggered or level-triggered. For an edge-triggered line, a low-to-high change of the recorded level sets a sticky pending latch. For a level-triggered line, the line itself is the pending condition for as long as it stays high.

The register side of the chip drives per-bit set and clear strobe vectors. These vectors act on the sticky latches only. The block reports the visible pending vector, which is the latch ORed with the level of every level-mode line. It also reports a registered copy of that vector masked by the enable bits, and a downstream arbiter consumes that copy.

Top module: `priv_irq_pending`

## Requirements
- R1: The mode bit `edgeMode[i]` selects the trigger type of line i: 1 means edge-triggered and 0 means level-triggered.
- R2: An edge-triggered line sets its latch only when its synchronised level changes from 0 to 1 relative to the recorded level. A line that is held high does not set the latch again after the latch is cleared.
- R3: A 1-to-0 change of an edge-triggered line leaves its latch unchanged.
- R4: `pendVis` equals the latch vector ORed with (recorded level AND NOT `edgeMode`). A level-mode line stops being visible once its low level has been recorded.
- R5: `setMask` and `clrMask` change only the latch. A level-mode line whose line is high stays visible through a clear. A set on a level-mode line whose line is low makes that line visible.
- R6: An input change passes through a two-stage synchroniser and one level register. It shows in `pendVis` after the third rising clock edge, and it does not show after the second.
- R7: `pendEn` is a register that holds `pendVis & enable` from the previous clock edge.
- R8: Asynchronous active-low reset clears the synchroniser, the recorded levels, the latches and `pendEn`.
- R9: Each latch bit is cleared by its `clrMask` bit. When a set (from `setMask` or from a rising edge) and a clear hit the same bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineIn | input | 16 | Raw interrupt line levels |
| edgeMode | input | 16 | Trigger mode per line, 1 = edge |
| setMask | input | 16 | One-cycle set-pending strobes per bit |
| clrMask | input | 16 | One-cycle clear-pending strobes per bit |
| enable | input | 16 | Enable mask applied to the registered output |
| pendVis | output | 16 | Visible pending vector |
| pendEn | output | 16 | Registered visible pending AND enable |

## Verification
The bench holds an edge-mode line high across a clear. A design that re-detected a level instead of a change would set the latch again. A clear is also applied to a level-mode line whose line is high. A design that cleared the live level, or that let strobes act on it, would drop a line that should stay visible. Edge-mode lines are released low to show that the latch survives the fall. A set and a clear are driven on the same bit in the same cycle to pin down which one wins. The synchroniser delay is checked on both sides of the third edge, so that a missing or an extra stage is caught.

// File: rtl/priv_irq_pkg.sv
package priv_irq_pkg;
  localparam int IRQ_W = 16;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic [IRQ_W-1:0] riseSeen;
    logic [IRQ_W-1:0] latchSet;
    logic [IRQ_W-1:0] latchClr;
  } pendStrobes_t;
endpackage

// File: rtl/priv_irq_ctrl.sv
module priv_irq_ctrl
  import priv_irq_pkg::*;
#(
  parameter int Width = IRQ_W,
  parameter int Stages = SYNC_STAGES
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [Width-1:0] lineIn,
  input  logic [Width-1:0] edgeMode,
  input  logic [Width-1:0] setMask,
  input  logic [Width-1:0] clrMask,
  output logic [Width-1:0] levelQ,
  output pendStrobes_t     strobes
);
  logic [Width-1:0] syncQ [Stages];

  // synchroniser chain
  generate
    for (genvar s = 0; s < Stages; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= lineIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  // recorded level, a change acts only against this copy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelQ <= '0;
    else levelQ <= syncQ[Stages-1];
  end

  logic [Width-1:0] riseV;
  always_comb begin
    riseV            = syncQ[Stages-1] & ~levelQ;
    strobes.riseSeen = riseV;
    strobes.latchSet = (riseV & edgeMode) | setMask;
    strobes.latchClr = clrMask;
  end
endmodule

// File: rtl/priv_irq_datapath.sv
module priv_irq_datapath
  import priv_irq_pkg::*;
#(
  parameter int Width = IRQ_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  pendStrobes_t     strobes,
  input  logic [Width-1:0] levelQ,
  input  logic [Width-1:0] edgeMode,
  input  logic [Width-1:0] enable,
  output logic [Width-1:0] latchQ,
  output logic [Width-1:0] pendVis,
  output logic [Width-1:0] pendEn
);
  // set is applied after clear, so set wins on a conflict
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchQ <= '0;
    else latchQ <= (latchQ & ~strobes.latchClr) | strobes.latchSet;
  end

  always_comb pendVis = latchQ | (levelQ & ~edgeMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendEn <= '0;
    else pendEn <= pendVis & enable;
  end
endmodule

// File: rtl/priv_irq_pending.sv
module priv_irq_pending
  import priv_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [IRQ_W-1:0] lineIn,
  input  logic [IRQ_W-1:0] edgeMode,
  input  logic [IRQ_W-1:0] setMask,
  input  logic [IRQ_W-1:0] clrMask,
  input  logic [IRQ_W-1:0] enable,
  output logic [IRQ_W-1:0] pendVis,
  output logic [IRQ_W-1:0] pendEn
);
  pendStrobes_t     strobes;
  logic [IRQ_W-1:0] levelQ;
  logic [IRQ_W-1:0] latchQ;

  priv_irq_ctrl #(.Width(IRQ_W), .Stages(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .edgeMode(edgeMode),
    .setMask(setMask), .clrMask(clrMask), .levelQ(levelQ), .strobes(strobes)
  );

  priv_irq_datapath #(.Width(IRQ_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .levelQ(levelQ),
    .edgeMode(edgeMode), .enable(enable), .latchQ(latchQ),
    .pendVis(pendVis), .pendEn(pendEn)
  );
endmodule

// File: rtl/priv_irq_pending_chk.sv
module priv_irq_pending_chk
  import priv_irq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [IRQ_W-1:0] edgeMode,
  input logic [IRQ_W-1:0] setMask,
  input logic [IRQ_W-1:0] clrMask,
  input logic [IRQ_W-1:0] enable,
  input logic [IRQ_W-1:0] levelQ,
  input logic [IRQ_W-1:0] latchQ,
  input logic [IRQ_W-1:0] riseSeen,
  input logic [IRQ_W-1:0] pendVis,
  input logic [IRQ_W-1:0] pendEn
);
  // R3: a latched bit is lost only through a clear strobe
  a_r3_latch_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(latchQ) & ~$past(clrMask) & ~latchQ) == '0));

  // R2: a latch bit rises only from a set strobe or an edge-mode rise
  a_r2_no_spurious_set: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((latchQ & ~$past(latchQ) & ~$past(setMask)
               & ~$past(riseSeen & edgeMode)) == '0));

  // R2: a detected rise becomes a new recorded high level
  a_r2_rise_recorded: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((levelQ & ~$past(levelQ)) == $past(riseSeen)));

  // R5: a high level-mode line is always visible
  a_r5_level_visible: assert property (@(posedge clk) disable iff (!rstN)
    ((levelQ & ~edgeMode & ~pendVis) == '0));

  // R7: registered output follows masked visible pending
  a_r7_enable_gate: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pendEn == $past(pendVis & enable)));

  // R9: set wins over clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(setMask) & ~latchQ) == '0));
endmodule

bind priv_irq_pending priv_irq_pending_chk u_chk (
  .clk(clk), .rstN(rstN), .edgeMode(edgeMode), .setMask(setMask),
  .clrMask(clrMask), .enable(enable), .levelQ(levelQ), .latchQ(latchQ),
  .riseSeen(strobes.riseSeen), .pendVis(pendVis), .pendEn(pendEn)
);

// File: tb/priv_irq_pending_tb.sv
`timescale 1ns/1ps
module priv_irq_pending_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] lineIn = '0, edgeMode = '0, setMask = '0, clrMask = '0, enable = '0;
  logic [15:0] pendVis, pendEn;
  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  priv_irq_pending u_dut (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .edgeMode(edgeMode),
    .setMask(setMask), .clrMask(clrMask), .enable(enable),
    .pendVis(pendVis), .pendEn(pendEn)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [15:0] s, input logic [15:0] c);
    setMask = s; clrMask = c;
    step(1);
    setMask = '0; clrMask = '0;
  endtask

  task automatic t_reset();
    chk("R8 reset pendVis", pendVis, 16'h0000);
    chk("R8 reset pendEn", pendEn, 16'h0000);
  endtask

  task automatic t_edge();
    edgeMode = 16'h0001;              // R1: bit0 edge, others level
    lineIn[0] = 1'b1;
    step(2);
    chk("R6 not yet visible after two edges", pendVis, 16'h0000);
    step(1);
    chk("R2 edge latched on rise", pendVis, 16'h0001);
    lineIn[0] = 1'b0;
    step(3);
    chk("R3 fall keeps latch", pendVis, 16'h0001);
    enable = 16'hFFFF;
    step(1);
    chk("R7 pendEn follows", pendEn, 16'h0001);
  endtask

  task automatic t_level();
    lineIn[1] = 1'b1;
    step(3);
    chk("R1 level line visible", pendVis, 16'h0003);
    pulse('0, 16'h0002);
    chk("R5 clear cannot hide high level", pendVis, 16'h0003);
    lineIn[1] = 1'b0;
    step(3);
    chk("R4 level line drops with line", pendVis, 16'h0001);
  endtask

  task automatic t_set_level();
    pulse(16'h0004, '0);
    chk("R5 set on low level line", pendVis, 16'h0005);
    pulse('0, 16'h0004);
    chk("R9 clear removes set", pendVis, 16'h0001);
  endtask

  task automatic t_held_high();
    lineIn[0] = 1'b1;
    step(3);
    pulse('0, 16'h0001);
    chk("R9 clear removes edge latch", pendVis, 16'h0000);
    step(4);
    chk("R2 held high does not relatch", pendVis, 16'h0000);
    lineIn[0] = 1'b0;
    step(3);
    lineIn[0] = 1'b1;
    step(3);
    chk("R2 new rise relatches", pendVis, 16'h0001);
  endtask

  task automatic t_conflict();
    pulse(16'h0008, 16'h0008);
    chk("R9 set wins over clear", pendVis, 16'h0009);
    enable = 16'h0008;
    step(1);
    chk("R7 enable masks output", pendEn, 16'h0008);
    enable = '0;
    step(1);
    chk("R7 all disabled", pendEn, 16'h0000);
  endtask

  task automatic t_mid_reset();
    enable = 16'hFFFF;
    step(1);
    rstN = 1'b0;
    step(1);
    chk("R8 reset clears pendVis", pendVis, 16'h0000);
    chk("R8 reset clears pendEn", pendEn, 16'h0000);
    rstN = 1'b1;
    step(3);
    chk("R6 R2 held line seen as new rise", pendVis, 16'h0001);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(2);
    rstN = 1'b1;
    step(1);
    t_reset();
    t_edge();
    t_level();
    t_set_level();
    t_held_high();
    t_conflict();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule